// File: doc/BRIEF.md
# Programmable DRAM Bank Decoder

This block turns a CPU byte address into the strobe pattern for a DRAM array. The array is split into four blocks, and each block holds one or two banks. Software programs each block with a base address and a depth code, and states whether the block has a second bank and whether its two banks alternate on consecutive 32-bit words. The size of a block follows from the bank depth and from that doubling, and the size decides how many base-address bits are compared. A block of 1 MB compares all eight base bits. A block of 128 MB compares only the top base bit.

For each valid lookup the decoder registers its outputs once. These are a hit flag, the index of the winning block, eight active-low row strobes, four active-low byte-lane column enables taken straight from the CPU byte enables, and the row and column parts of the word address inside the selected bank. Access timing, refresh and parity sit outside this block.

Top module: `dram_dec`

## Requirements
- R1: While `rstN` is low, and after it rises until the first lookup, `hit`=0, `blockSel`=0, `rasN`=8'hFF, `casN`=4'hF and `rowAddr`=`colAddr`=0. Reset leaves every block with depth code 0.
- R2: A block whose depth code `cfgData[10:8]` is 0 (none) or 5 to 7 never hits. The codes 1, 2, 3 and 4 stand for 256K, 1M, 4M and 16M words of 4 bytes.
- R3: Bank bytes = depth × 4. Block bytes = bank bytes, doubled when `cfgData[11]` (two banks) or `cfgData[12]` (interleave) is set. A block hits when `cpuAddr[31:28]` is 0 and `cpuAddr[27:20]` equals the base `cfgData[7:0]` in every bit at or above log2(block bytes)−20.
- R4: When more than one block hits, the block with the lowest index wins and is reported on `blockSel`.
- R5: A hit in a block n that has one bank drives only `rasN[n]` low.
- R6: In a block n with two banks and no interleave, address bit 20+log2(bank bytes/1 MB) selects `rasN[n]` (0) or `rasN[n+4]` (1).
- R7: In a block n with two banks and interleave, `cpuAddr[2]` selects `rasN[n]` (0) or `rasN[n+4]` (1).
- R8: On a hit, `casN` = ~`cpuByteEn`, with bit i standing for byte lane i. Otherwise `casN` = 4'hF.
- R9: The word address is `cpuAddr`>>2, or >>3 when the block has two banks and interleave. With c = 9, 10, 11 or 12 for depth codes 1 to 4, `colAddr` is the low c bits of the word address and `rowAddr` is the next c bits. Both are 0 on a miss.
- R10: The outputs change one clock after the lookup is sampled. With `cpuValid` low, the next outputs are idle: no hit and all strobes high.
- R11: A write with `cfgWe`=1 and `cfgIdx`=n loads block n at the clock edge. A lookup sampled on that same edge still uses the old settings, and lookups from the next edge on use the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Write strobe for block settings |
| cfgIdx | input | 2 | Block being written |
| cfgData | input | 13 | {interleave, twoBanks, depth[2:0], base[7:0]} |
| cpuValid | input | 1 | Lookup request |
| cpuAddr | input | 32 | CPU byte address |
| cpuByteEn | input | 4 | Byte-lane enables, active high |
| hit | output | 1 | Registered block hit |
| blockSel | output | 2 | Index of the winning block |
| rasN | output | 8 | Row strobes, active low |
| casN | output | 4 | Byte-lane column enables, active low |
| rowAddr | output | 12 | Row part of the bank word address |
| colAddr | output | 12 | Column part of the bank word address |

## Verification
Each block's settings live in a register that the ports never show directly, so a corrupted base, depth or bank flag shows up only as a wrong hit, a wrong strobe or a wrong address split. It shows up one clock after the first lookup that lands near the affected boundary. The bench keeps its own copy of the settings, predicts all outputs on every clock, and aims lookups just inside and just outside each block edge and at each bank-select bit. A fault in the priority or in the strobe pairing then shows on the very next output cycle.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  localparam int NUM_BLOCKS = 4;
  localparam int BLK_W      = $clog2(NUM_BLOCKS);
  localparam int RAS_W      = 2 * NUM_BLOCKS;
  localparam int LANES      = 4;
  localparam int START_W    = 8;
  localparam int START_LSB  = 20;
  localparam int TOP_LSB    = START_LSB + START_W;
  localparam int DEPTH_W    = 3;
  localparam int MIN_COL_W  = 9;
  localparam int RC_W       = MIN_COL_W + 3;

  localparam logic [DEPTH_W-1:0] DEPTH_NONE = 3'd0;
  localparam logic [DEPTH_W-1:0] DEPTH_256K = 3'd1;
  localparam logic [DEPTH_W-1:0] DEPTH_16M  = 3'd4;

  // Settings of one block as laid out on the write port
  typedef struct packed {
    logic               inter;
    logic               twoBanks;
    logic [DEPTH_W-1:0] depth;
    logic [START_W-1:0] start;
  } blkCfg_t;

  localparam int CFG_W = $bits(blkCfg_t);

  // Strobes passed from the match/priority control to the datapath
  typedef struct packed {
    logic               hit;
    logic [BLK_W-1:0]   blk;
    logic               upper;
    logic               wideWord;
    logic [DEPTH_W-1:0] depth;
  } decStrobe_t;
endpackage

// File: rtl/dram_dec_ctrl.sv
module dram_dec_ctrl
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [BLK_W-1:0]  cfgIdx,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [ADDR_W-1:0] cpuAddr,
  output decStrobe_t        strobe
);
  localparam int IL_BIT = $clog2(LANES);

  blkCfg_t               cfgQ [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] matchVec;
  logic [NUM_BLOCKS-1:0] upperVec;
  logic [NUM_BLOCKS-1:0] wideVec;
  logic [NUM_BLOCKS-1:0] lowMask;
  logic                  addrHiZero;

  assign addrHiZero = (cpuAddr[ADDR_W-1:TOP_LSB] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BLOCKS; i++) cfgQ[i] <= '0;
    end else if (cfgWe) begin
      cfgQ[cfgIdx] <= blkCfg_t'(cfgData);
    end
  end

  // One compare slice per block
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic               populated;
    logic               dual;
    logic [2:0]         bankLog;
    logic [3:0]         sizeLog;
    logic [START_W-1:0] cmpMask;
    logic [START_W-1:0] diff;
    logic               bankBit;

    always_comb begin
      populated = (cfgQ[b].depth >= DEPTH_256K) && (cfgQ[b].depth <= DEPTH_16M);
      bankLog   = {cfgQ[b].depth[1:0] - 2'd1, 1'b0};
      dual      = cfgQ[b].twoBanks | cfgQ[b].inter;
      sizeLog   = {1'b0, bankLog} + {3'b000, dual};
      cmpMask   = {START_W{1'b1}} << sizeLog;
      diff      = cpuAddr[TOP_LSB-1:START_LSB] ^ cfgQ[b].start;
      bankBit   = cfgQ[b].inter ? cpuAddr[IL_BIT] : cpuAddr[START_LSB + int'(bankLog)];
    end

    assign matchVec[b] = populated && addrHiZero && ((diff & cmpMask) == '0);
    assign upperVec[b] = cfgQ[b].twoBanks && bankBit;
    assign wideVec[b]  = cfgQ[b].twoBanks && cfgQ[b].inter;
  end

  // Lowest index wins
  always_comb begin
    strobe = '0;
    for (int i = NUM_BLOCKS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        strobe.hit      = 1'b1;
        strobe.blk      = BLK_W'(i);
        strobe.upper    = upperVec[i];
        strobe.wideWord = wideVec[i];
        strobe.depth    = cfgQ[i].depth;
      end
    end
  end

  assign lowMask = (NUM_BLOCKS'(1) << strobe.blk) - NUM_BLOCKS'(1);

  a_r4_lowest_match_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hit |-> (matchVec[strobe.blk] && ((matchVec & lowMask) == '0)));

  a_r2_winner_populated: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hit |-> ((cfgQ[strobe.blk].depth != DEPTH_NONE) &&
                    (cfgQ[strobe.blk].depth <= DEPTH_16M)));

  a_r3_high_bits_miss: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1:TOP_LSB] != '0) |-> !strobe.hit);
endmodule

// File: rtl/dram_dec_dp.sv
module dram_dec_dp
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [LANES-1:0]  cpuByteEn,
  input  decStrobe_t        strobe,
  output logic              hit,
  output logic [BLK_W-1:0]  blockSel,
  output logic [RAS_W-1:0]  rasN,
  output logic [LANES-1:0]  casN,
  output logic [RC_W-1:0]   rowAddr,
  output logic [RC_W-1:0]   colAddr
);
  localparam int LANE_LSB = $clog2(LANES);
  localparam int RAS_IW   = $clog2(RAS_W);

  logic              take;
  logic [3:0]        colBits;
  logic [ADDR_W-1:0] wordAddr;
  logic [ADDR_W-1:0] rowWord;
  logic [RC_W-1:0]   rcMask;
  logic [RC_W-1:0]   rowNext;
  logic [RC_W-1:0]   colNext;
  logic [RAS_IW-1:0] rasIdx;
  logic [RAS_W-1:0]  rasNext;

  always_comb begin
    take     = cpuValid && strobe.hit;
    colBits  = 4'(MIN_COL_W) + {2'b00, strobe.depth[1:0] - 2'd1};
    wordAddr = strobe.wideWord ? (cpuAddr >> (LANE_LSB + 1)) : (cpuAddr >> LANE_LSB);
    rowWord  = wordAddr >> colBits;
    rcMask   = ~({RC_W{1'b1}} << colBits);
    colNext  = wordAddr[RC_W-1:0] & rcMask;
    rowNext  = rowWord[RC_W-1:0] & rcMask;
    rasIdx   = {strobe.upper, strobe.blk};
    rasNext  = '1;
    if (take) rasNext[rasIdx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit      <= 1'b0;
      blockSel <= '0;
      rasN     <= '1;
      casN     <= '1;
      rowAddr  <= '0;
      colAddr  <= '0;
    end else begin
      hit      <= take;
      blockSel <= take ? strobe.blk : '0;
      rasN     <= rasNext;
      casN     <= take ? ~cpuByteEn : '1;
      rowAddr  <= take ? rowNext : '0;
      colAddr  <= take ? colNext : '0;
    end
  end

  a_r10_idle_after_no_request: assert property (@(posedge clk) disable iff (!rstN)
    !cpuValid |=> (!hit && (rasN == '1) && (casN == '1)));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ($countones(~rasN) == 1));

  a_r6_strobe_in_pair: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (!rasN[{1'b0, blockSel}] || !rasN[{1'b1, blockSel}]));

  a_r8_lanes_quiet_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (casN == '1));
endmodule

// File: rtl/dram_dec.sv
module dram_dec
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [BLK_W-1:0]  cfgIdx,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              cpuValid,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [LANES-1:0]  cpuByteEn,
  output logic              hit,
  output logic [BLK_W-1:0]  blockSel,
  output logic [RAS_W-1:0]  rasN,
  output logic [LANES-1:0]  casN,
  output logic [RC_W-1:0]   rowAddr,
  output logic [RC_W-1:0]   colAddr
);
  decStrobe_t strobe;

  dram_dec_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgIdx  (cfgIdx),
    .cfgData (cfgData),
    .cpuAddr (cpuAddr),
    .strobe  (strobe)
  );

  dram_dec_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuValid  (cpuValid),
    .cpuAddr   (cpuAddr),
    .cpuByteEn (cpuByteEn),
    .strobe    (strobe),
    .hit       (hit),
    .blockSel  (blockSel),
    .rasN      (rasN),
    .casN      (casN),
    .rowAddr   (rowAddr),
    .colAddr   (colAddr)
  );
endmodule

// File: tb/tb_dram_dec.sv
`timescale 1ns/1ps
module tb_dram_dec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [12:0] cfgData = '0;
  logic        cpuValid = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic [3:0]  cpuByteEn = '0;
  logic        hit;
  logic [1:0]  blockSel;
  logic [7:0]  rasN;
  logic [3:0]  casN;
  logic [11:0] rowAddr, colAddr;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string curTag = "R1";

  always #2 clk = ~clk;

  dram_dec dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .cpuValid(cpuValid), .cpuAddr(cpuAddr), .cpuByteEn(cpuByteEn),
    .hit(hit), .blockSel(blockSel), .rasN(rasN), .casN(casN),
    .rowAddr(rowAddr), .colAddr(colAddr)
  );

  // Behavioural reference model
  int          mStart [4];
  int          mDepth [4];
  int          mTwo   [4];
  int          mIl    [4];
  logic        eHit;
  logic [1:0]  eBlk;
  logic [7:0]  eRas;
  logic [3:0]  eCas;
  logic [11:0] eRow, eCol;
  longint      aL, bankBytes, blkBytes, words, span;
  int          up;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 4; b++) begin
        mStart[b] = 0; mDepth[b] = 0; mTwo[b] = 0; mIl[b] = 0;
      end
      eHit = 0; eBlk = 0; eRas = 8'hFF; eCas = 4'hF; eRow = 0; eCol = 0;
    end else begin
      eHit = 0; eBlk = 0; eRas = 8'hFF; eCas = 4'hF; eRow = 0; eCol = 0;
      aL = longint'(cpuAddr);
      if (cpuValid) begin
        for (int b = 0; b < 4; b++) begin
          if (!eHit && mDepth[b] >= 1 && mDepth[b] <= 4) begin
            bankBytes = 64'd1048576 * (4 ** (mDepth[b] - 1));
            blkBytes  = bankBytes * ((mTwo[b] != 0 || mIl[b] != 0) ? 2 : 1);
            if (aL < 64'd268435456 &&
                (aL / blkBytes) == ((longint'(mStart[b]) * 1048576) / blkBytes)) begin
              eHit = 1;
              eBlk = 2'(b);
              up = 0;
              if (mTwo[b] != 0) up = (mIl[b] != 0) ? int'((aL / 4) % 2) : int'((aL / bankBytes) % 2);
              eRas = 8'hFF & ~(8'h01 << (b + 4 * up));
              eCas = ~cpuByteEn;
              words = (mTwo[b] != 0 && mIl[b] != 0) ? aL / 8 : aL / 4;
              span  = 512 * (2 ** (mDepth[b] - 1));
              eCol  = 12'(words % span);
              eRow  = 12'((words / span) % span);
            end
          end
        end
      end
      if (cfgWe) begin
        mStart[cfgIdx] = int'(cfgData[7:0]);
        mDepth[cfgIdx] = int'(cfgData[10:8]);
        mTwo[cfgIdx]   = int'(cfgData[11]);
        mIl[cfgIdx]    = int'(cfgData[12]);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if ({hit, blockSel, rasN, casN, rowAddr, colAddr} !== {eHit, eBlk, eRas, eCas, eRow, eCol}) begin
        fails++;
        $display("FAIL %s: got hit=%0b blk=%0d ras=%h cas=%h row=%h col=%h, expected hit=%0b blk=%0d ras=%h cas=%h row=%h col=%h",
                 curTag, hit, blockSel, rasN, casN, rowAddr, colAddr,
                 eHit, eBlk, eRas, eCas, eRow, eCol);
      end
    end
  end

  task automatic setCfg(int idx, int st, int dep, int two, int il);
    @(negedge clk);
    cfgWe    = 1'b1;
    cfgIdx   = 2'(idx);
    cfgData  = 13'((il << 12) | (two << 11) | (dep << 8) | st);
    cpuValid = 1'b0;
  endtask

  task automatic lookup(logic [31:0] a, logic [3:0] be);
    @(negedge clk);
    cfgWe     = 1'b0;
    cpuValid  = 1'b1;
    cpuAddr   = a;
    cpuByteEn = be;
  endtask

  task automatic idle();
    @(negedge clk);
    cfgWe    = 1'b0;
    cpuValid = 1'b0;
  endtask

  initial begin
    curTag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(); idle();
    lookup(32'h0000_0000, 4'hF);   // R1: nothing configured, miss
    lookup(32'h0123_4560, 4'h3);

    curTag = "R2";
    setCfg(0, 8'h00, 0, 0, 0);
    lookup(32'h0000_0100, 4'hF);
    setCfg(0, 8'h00, 5, 1, 0);
    lookup(32'h0000_0100, 4'hF);
    setCfg(0, 8'h00, 7, 0, 1);
    lookup(32'h0010_0000, 4'hF);

    curTag = "R3";
    setCfg(0, 8'h08, 2, 0, 0);     // 4 MB block at 8 MB
    lookup(32'h0080_0000, 4'hF);
    lookup(32'h00BF_FFFC, 4'hF);
    lookup(32'h007F_FFFC, 4'hF);
    lookup(32'h00C0_0000, 4'hF);
    lookup(32'h1080_0000, 4'hF);
    setCfg(0, 8'h0B, 2, 0, 0);     // low base bits ignored
    lookup(32'h0081_2344, 4'hF);

    curTag = "R5";
    lookup(32'h00A0_0010, 4'hF);

    curTag = "R6";
    setCfg(1, 8'h20, 1, 1, 0);     // two 1 MB banks at 32 MB
    lookup(32'h0200_0010, 4'hF);
    lookup(32'h0210_0010, 4'hF);
    lookup(32'h021F_FFFC, 4'hF);
    lookup(32'h0220_0000, 4'hF);

    curTag = "R7";
    setCfg(2, 8'h40, 3, 1, 1);     // two 16 MB banks interleaved at 64 MB
    lookup(32'h0400_0000, 4'hF);
    lookup(32'h0400_0004, 4'hF);
    lookup(32'h05FF_FFFC, 4'hF);
    lookup(32'h0600_0000, 4'hF);

    curTag = "R4";
    setCfg(3, 8'h20, 4, 0, 0);     // 64 MB block covering 0..64 MB
    lookup(32'h0081_0000, 4'hF);
    lookup(32'h0200_0010, 4'hF);
    lookup(32'h0300_0000, 4'hF);

    curTag = "R8";
    lookup(32'h0081_0000, 4'h1);
    lookup(32'h0081_0000, 4'hA);
    lookup(32'h0081_0000, 4'h0);
    lookup(32'h0F00_0000, 4'h5);

    curTag = "R9";
    lookup(32'h00BF_FFFC, 4'hF);
    lookup(32'h0411_2238, 4'hF);
    lookup(32'h0411_223C, 4'hF);
    lookup(32'h03FF_FFFC, 4'hF);

    curTag = "R11";
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 2'd0; cfgData = 13'h0000;   // block 0 emptied
    cpuValid = 1'b1; cpuAddr = 32'h0081_0000; cpuByteEn = 4'hF;
    lookup(32'h0081_0000, 4'hF);
    setCfg(0, 8'h08, 2, 0, 0);
    lookup(32'h0081_0000, 4'hF);

    curTag = "R10";
    idle();
    @(negedge clk);
    cpuValid = 1'b0; cpuAddr = 32'h0081_0000;
    idle();

    curTag = "R3";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 15) == 0)
        setCfg(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 7)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
      else if ($urandom_range(0, 9) == 0)
        idle();
      else
        lookup($urandom() & 32'h1FFF_FFFF, 4'($urandom_range(0, 15)));
    end
    idle(); idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog %s: got no end of test, expected end within the cycle budget", curTag);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule